// File: doc/BRIEF.md
# Single-Issue Instruction Fetch Stage

This block is the front stage of a pipelined processor. It owns the program counter and issues one fetch per cycle to an instruction cache. The address it sends is the program counter rounded down to the start of a cache block. The cache answers in the same cycle with a hit flag and the whole block. The stage then selects the 32-bit word that the program counter points at and places it in an output register for decode. That register carries the word, its address, a predicted-taken flag and a sequence tag.

A branch predictor is looked up with the current program counter. If it reports a taken branch, the next fetch goes to the predicted target. Otherwise the next fetch is the following word. A miss stalls the stage until the cache signals that the fill has finished, and the stage then asks again. Decode can hold the stage by withdrawing ready. Two redirect inputs, one from decode and one from the later stages, flush the output and restart fetching at a new address. The decode redirect also restarts the sequence tags. Three counters report miss-stall cycles, fetched instructions and taken predictions.

Top module: `fetch_stage`

## Requirements
- R1: During reset and in the first cycle after it the stage is idle. No request is made, the output is not valid, all three counters read 0 and the lookup address equals the reset vector (default 0x1008). In the next cycle the stage requests the block that holds the reset vector.
- R2: The request address is the program counter with bits [3:0] cleared. The delivered instruction is the 32-bit word of the returned block at word index pc[3:2]. Word k occupies line bits [32k+31:32k].
- R3: When a request hits, the instruction, its address and the predictor's taken flag for that cycle are on the output with valid high from the next cycle.
- R4: After a hit the program counter advances by 4. If the predictor reported taken in that cycle, it moves to the predicted target instead.
- R5: After a miss, the output is not valid and no request is made until the fill-done input is seen. The following cycle repeats the request for the same block, and a hit then delivers the instruction.
- R6: While the output is valid and decode is not ready, the output stays valid with the same address and word, and no request is made. The cycle after ready returns, the output drops and fetching resumes with the next address.
- R7: A redirect flushes the output in the next cycle and makes no request in that cycle. In the cycle after that, the block of the redirect address is requested. If both redirects arrive together, the later-stage one wins.
- R8: Sequence tags start at 0 after reset and rise by 1 for each instruction delivered. After a decode redirect carrying tag S (when it wins), the first instruction delivered carries S+1.
- R9: A fill-done that arrives for a miss abandoned by a redirect is ignored. A new miss at the redirect address keeps waiting for the next fill-done.
- R10: A redirect takes priority over a hit in the same cycle. No instruction from that cycle is delivered and the fetched count does not advance.
- R11: The counters count cycles spent waiting on a miss, instructions fetched on hits, and hits for which a taken prediction was reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ic_req_valid | output | 1 | Fetch request to the cache this cycle |
| ic_req_addr | output | ADDR_W | Block-aligned request address |
| ic_resp_hit | input | 1 | Same-cycle hit answer for the request |
| ic_resp_line | input | BLK_BYTES*8 | Block data returned on a hit |
| ic_fill_done | input | 1 | Outstanding miss has been filled |
| bp_pc | output | ADDR_W | Address looked up in the predictor |
| bp_taken | input | 1 | Predictor reports a taken branch |
| bp_target | input | ADDR_W | Predicted target address |
| sq_late_valid | input | 1 | Redirect from later stages |
| sq_late_pc | input | ADDR_W | Redirect address from later stages |
| sq_dec_valid | input | 1 | Redirect from decode |
| sq_dec_pc | input | ADDR_W | Redirect address from decode |
| sq_dec_seq | input | SEQ_W | Sequence tag of the decode redirect |
| dec_ready | input | 1 | Decode can accept the output |
| dec_valid | output | 1 | Output holds an instruction |
| dec_inst | output | INST_W | Fetched instruction word |
| dec_pc | output | ADDR_W | Address of the instruction |
| dec_pred_taken | output | 1 | Taken prediction made at fetch |
| dec_seq | output | SEQ_W | Sequence tag |
| stat_miss_cycles | output | CNT_W | Cycles spent waiting on a miss |
| stat_fetched | output | CNT_W | Instructions fetched |
| stat_pred_taken | output | CNT_W | Taken predictions used |

## Verification
A table of redirect addresses is run through the fetch path. Each entry is either not predicted or predicted taken, and the cases are chosen so the fall-through address and the target land in different blocks. A wrong block mask, a wrong word index or a wrong next-address choice therefore shows up as a different request address or delivered address. Streams of consecutive hits, a decode hold, a multi-cycle miss and redirects are each checked separately. The redirects are a later-stage redirect alone, one that collides with a hit, one that arrives together with a decode redirect, and one that abandons a miss. These separate the hold, stall, priority and stale-fill paths, and the counters are compared with the number of cycles and fetches each scenario should produce.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int unsigned DEF_ADDR_W    = 32;
    localparam int unsigned DEF_INST_W    = 32;
    localparam int unsigned DEF_BLK_BYTES = 16;
    localparam int unsigned DEF_SEQ_W     = 8;
    localparam int unsigned DEF_CNT_W     = 16;
    localparam int unsigned NUM_STATS     = 3;

    typedef enum logic [2:0] {
        FS_IDLE      = 3'd0,
        FS_RUN       = 3'd1,
        FS_SQUASH    = 3'd2,
        FS_BLOCK     = 3'd3,
        FS_MISS_WAIT = 3'd4,
        FS_MISS_DONE = 3'd5
    } fetch_state_e;

    typedef struct packed {
        logic pred_hit;
        logic fetch_hit;
        logic miss_wait;
    } stat_ev_t;

    function automatic logic can_issue(fetch_state_e st);
        return (st == FS_RUN) || (st == FS_MISS_DONE);
    endfunction

endpackage

// File: rtl/fetch_ctrl.sv
module fetch_ctrl
    import fetch_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         squash_any,
    input  logic         out_valid,
    input  logic         dec_ready,
    input  logic         resp_hit,
    input  logic         fill_done,
    output fetch_state_e state,
    output logic         fetch_en,
    output logic         fetch_hit
);

    fetch_state_e state_nx;
    logic         ignore_fill;

    assign fetch_en  = !squash_any && can_issue(state) && (!out_valid || dec_ready);
    assign fetch_hit = fetch_en && resp_hit;

    always_comb begin
        state_nx = state;
        if (squash_any) begin
            state_nx = FS_SQUASH;
        end else begin
            unique case (state)
                FS_IDLE, FS_SQUASH: state_nx = FS_RUN;
                FS_RUN, FS_MISS_DONE: begin
                    if (fetch_en)
                        state_nx = resp_hit ? FS_RUN : FS_MISS_WAIT;
                    else if (out_valid && !dec_ready)
                        state_nx = FS_BLOCK;
                end
                FS_BLOCK:     if (dec_ready) state_nx = FS_RUN;
                FS_MISS_WAIT: if (fill_done && !ignore_fill) state_nx = FS_MISS_DONE;
                default:      state_nx = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= FS_IDLE;
            ignore_fill <= 1'b0;
        end else begin
            state <= state_nx;
            if (squash_any && state == FS_MISS_WAIT && !fill_done)
                ignore_fill <= 1'b1;
            else if (fill_done)
                ignore_fill <= 1'b0;
        end
    end

    a_r1_idle_to_run: assert property (@(posedge clk) disable iff (rst)
        (state == FS_IDLE && !squash_any) |=> state == FS_RUN);

    a_r5_miss_enters_wait: assert property (@(posedge clk) disable iff (rst)
        (fetch_en && !resp_hit) |=> state == FS_MISS_WAIT);

    a_r7_squash_state: assert property (@(posedge clk) disable iff (rst)
        squash_any |=> state == FS_SQUASH);

    a_r9_stale_fill_dropped: assert property (@(posedge clk) disable iff (rst)
        (state == FS_MISS_WAIT && fill_done && ignore_fill && !squash_any)
        |=> state == FS_MISS_WAIT);

    a_r6_block_no_fetch: assert property (@(posedge clk) disable iff (rst)
        (state == FS_BLOCK) |-> !fetch_en);

endmodule

// File: rtl/fetch_pc.sv
module fetch_pc #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned INST_W    = 32,
    parameter int unsigned BLK_BYTES = 16,
    parameter int unsigned SEQ_W     = 8,
    parameter logic [ADDR_W-1:0] RESET_VEC = '0,
    localparam int unsigned OFF_W  = $clog2(BLK_BYTES),
    localparam int unsigned IB_W   = $clog2(INST_W/8),
    localparam int unsigned WSEL_W = OFF_W - IB_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sq_late_valid,
    input  logic [ADDR_W-1:0] sq_late_pc,
    input  logic              sq_dec_valid,
    input  logic [ADDR_W-1:0] sq_dec_pc,
    input  logic [SEQ_W-1:0]  sq_dec_seq,
    input  logic              fetch_hit,
    input  logic              bp_taken,
    input  logic [ADDR_W-1:0] bp_target,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] blk_addr,
    output logic [WSEL_W-1:0] wsel,
    output logic [SEQ_W-1:0]  seq
);

    localparam logic [ADDR_W-1:0] BLK_MASK   = ADDR_W'(BLK_BYTES - 1);
    localparam logic [ADDR_W-1:0] INST_BYTES = ADDR_W'(INST_W / 8);

    assign blk_addr = pc & ~BLK_MASK;
    assign wsel     = pc[OFF_W-1:IB_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            pc  <= RESET_VEC;
            seq <= '0;
        end else if (sq_late_valid) begin
            pc <= sq_late_pc;
        end else if (sq_dec_valid) begin
            pc  <= sq_dec_pc;
            seq <= sq_dec_seq + SEQ_W'(1);
        end else if (fetch_hit) begin
            pc  <= bp_taken ? bp_target : pc + INST_BYTES;
            seq <= seq + SEQ_W'(1);
        end
    end

    a_r4_taken_target: assert property (@(posedge clk) disable iff (rst)
        (fetch_hit && bp_taken && !sq_late_valid && !sq_dec_valid)
        |=> pc == $past(bp_target));

    a_r4_fall_through: assert property (@(posedge clk) disable iff (rst)
        (fetch_hit && !bp_taken && !sq_late_valid && !sq_dec_valid)
        |=> pc == $past(pc) + INST_BYTES);

    a_r8_dec_seq_restart: assert property (@(posedge clk) disable iff (rst)
        (sq_dec_valid && !sq_late_valid) |=> seq == $past(sq_dec_seq) + SEQ_W'(1));

    a_r7_late_wins: assert property (@(posedge clk) disable iff (rst)
        sq_late_valid |=> pc == $past(sq_late_pc));

endmodule

// File: rtl/fetch_out.sv
module fetch_out #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned INST_W    = 32,
    parameter int unsigned BLK_BYTES = 16,
    parameter int unsigned SEQ_W     = 8,
    localparam int unsigned LINE_W = BLK_BYTES * 8,
    localparam int unsigned WSEL_W = $clog2(BLK_BYTES) - $clog2(INST_W/8)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              squash_any,
    input  logic              fetch_hit,
    input  logic              dec_ready,
    input  logic [LINE_W-1:0] line,
    input  logic [WSEL_W-1:0] wsel,
    input  logic [ADDR_W-1:0] pc,
    input  logic              pred,
    input  logic [SEQ_W-1:0]  seq,
    output logic              out_valid,
    output logic [INST_W-1:0] out_inst,
    output logic [ADDR_W-1:0] out_pc,
    output logic              out_pred,
    output logic [SEQ_W-1:0]  out_seq
);

    logic [INST_W-1:0] word_sel;

    assign word_sel = line[int'(wsel)*INST_W +: INST_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_inst  <= '0;
            out_pc    <= '0;
            out_pred  <= 1'b0;
            out_seq   <= '0;
        end else if (squash_any) begin
            out_valid <= 1'b0;
        end else if (fetch_hit) begin
            out_valid <= 1'b1;
            out_inst  <= word_sel;
            out_pc    <= pc;
            out_pred  <= pred;
            out_seq   <= seq;
        end else if (dec_ready) begin
            out_valid <= 1'b0;
        end
    end

    a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !dec_ready && !squash_any)
        |=> (out_valid && $stable(out_pc) && $stable(out_inst) && $stable(out_seq)));

    a_r10_squash_flush: assert property (@(posedge clk) disable iff (rst)
        squash_any |=> !out_valid);

    a_r3_hit_delivers: assert property (@(posedge clk) disable iff (rst)
        (fetch_hit && !squash_any) |=> (out_valid && out_pc == $past(pc)));

endmodule

// File: rtl/fetch_stats.sv
module fetch_stats #(
    parameter int unsigned N     = 3,
    parameter int unsigned CNT_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [N-1:0]             ev,
    output logic [N-1:0][CNT_W-1:0]  cnt
);

    for (genvar i = 0; i < N; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst)
                cnt[i] <= '0;
            else if (ev[i])
                cnt[i] <= cnt[i] + CNT_W'(1);
        end

        a_r11_count_step: assert property (@(posedge clk) disable iff (rst)
            ev[i] |=> cnt[i] == $past(cnt[i]) + CNT_W'(1));
    end

endmodule

// File: rtl/fetch_stage.sv
module fetch_stage
    import fetch_pkg::*;
#(
    parameter int unsigned ADDR_W    = DEF_ADDR_W,
    parameter int unsigned INST_W    = DEF_INST_W,
    parameter int unsigned BLK_BYTES = DEF_BLK_BYTES,
    parameter int unsigned SEQ_W     = DEF_SEQ_W,
    parameter int unsigned CNT_W     = DEF_CNT_W,
    parameter logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(32'h0000_1008)
) (
    input  logic                   clk,
    input  logic                   rst,
    output logic                   ic_req_valid,
    output logic [ADDR_W-1:0]      ic_req_addr,
    input  logic                   ic_resp_hit,
    input  logic [BLK_BYTES*8-1:0] ic_resp_line,
    input  logic                   ic_fill_done,
    output logic [ADDR_W-1:0]      bp_pc,
    input  logic                   bp_taken,
    input  logic [ADDR_W-1:0]      bp_target,
    input  logic                   sq_late_valid,
    input  logic [ADDR_W-1:0]      sq_late_pc,
    input  logic                   sq_dec_valid,
    input  logic [ADDR_W-1:0]      sq_dec_pc,
    input  logic [SEQ_W-1:0]       sq_dec_seq,
    input  logic                   dec_ready,
    output logic                   dec_valid,
    output logic [INST_W-1:0]      dec_inst,
    output logic [ADDR_W-1:0]      dec_pc,
    output logic                   dec_pred_taken,
    output logic [SEQ_W-1:0]       dec_seq,
    output logic [CNT_W-1:0]       stat_miss_cycles,
    output logic [CNT_W-1:0]       stat_fetched,
    output logic [CNT_W-1:0]       stat_pred_taken
);

    localparam int unsigned WSEL_W = $clog2(BLK_BYTES) - $clog2(INST_W/8);

    fetch_state_e                   state;
    logic                           squash_any;
    logic                           fetch_en;
    logic                           fetch_hit;
    logic [ADDR_W-1:0]              pc;
    logic [WSEL_W-1:0]              wsel;
    logic [SEQ_W-1:0]               seq;
    stat_ev_t                       ev;
    logic [NUM_STATS-1:0][CNT_W-1:0] cnt;

    assign squash_any   = sq_late_valid || sq_dec_valid;
    assign ic_req_valid = fetch_en;
    assign bp_pc        = pc;

    fetch_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .squash_any (squash_any),
        .out_valid  (dec_valid),
        .dec_ready  (dec_ready),
        .resp_hit   (ic_resp_hit),
        .fill_done  (ic_fill_done),
        .state      (state),
        .fetch_en   (fetch_en),
        .fetch_hit  (fetch_hit)
    );

    fetch_pc #(
        .ADDR_W    (ADDR_W),
        .INST_W    (INST_W),
        .BLK_BYTES (BLK_BYTES),
        .SEQ_W     (SEQ_W),
        .RESET_VEC (RESET_VEC)
    ) u_pc (
        .clk           (clk),
        .rst           (rst),
        .sq_late_valid (sq_late_valid),
        .sq_late_pc    (sq_late_pc),
        .sq_dec_valid  (sq_dec_valid),
        .sq_dec_pc     (sq_dec_pc),
        .sq_dec_seq    (sq_dec_seq),
        .fetch_hit     (fetch_hit),
        .bp_taken      (bp_taken),
        .bp_target     (bp_target),
        .pc            (pc),
        .blk_addr      (ic_req_addr),
        .wsel          (wsel),
        .seq           (seq)
    );

    fetch_out #(
        .ADDR_W    (ADDR_W),
        .INST_W    (INST_W),
        .BLK_BYTES (BLK_BYTES),
        .SEQ_W     (SEQ_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .squash_any (squash_any),
        .fetch_hit  (fetch_hit),
        .dec_ready  (dec_ready),
        .line       (ic_resp_line),
        .wsel       (wsel),
        .pc         (pc),
        .pred       (bp_taken),
        .seq        (seq),
        .out_valid  (dec_valid),
        .out_inst   (dec_inst),
        .out_pc     (dec_pc),
        .out_pred   (dec_pred_taken),
        .out_seq    (dec_seq)
    );

    assign ev.miss_wait = (state == FS_MISS_WAIT);
    assign ev.fetch_hit = fetch_hit;
    assign ev.pred_hit  = fetch_hit && bp_taken;

    fetch_stats #(
        .N     (NUM_STATS),
        .CNT_W (CNT_W)
    ) u_stats (
        .clk (clk),
        .rst (rst),
        .ev  (ev),
        .cnt (cnt)
    );

    assign stat_miss_cycles = cnt[0];
    assign stat_fetched     = cnt[1];
    assign stat_pred_taken  = cnt[2];

    a_r5_wait_no_request: assert property (@(posedge clk) disable iff (rst)
        (state == FS_MISS_WAIT) |-> !ic_req_valid);

    a_r10_squash_no_count: assert property (@(posedge clk) disable iff (rst)
        squash_any |=> stat_fetched == $past(stat_fetched));

endmodule

// File: tb/sim_fetch_stage.sv
`timescale 1ns/1ps
module sim_fetch_stage;

    localparam logic [31:0] KEY = 32'hA5A5_0000;

    typedef struct packed {
        logic [31:0] start;
        logic        tk;
        logic [31:0] tgt;
        logic [31:0] nxt;
    } vec_t;

    localparam vec_t VEC [4] = '{
        '{32'h0000_2000, 1'b0, 32'h0000_0000, 32'h0000_2004},
        '{32'h0000_200C, 1'b0, 32'h0000_0000, 32'h0000_2010},
        '{32'h0000_3004, 1'b1, 32'h0000_4008, 32'h0000_4008},
        '{32'h0000_3FFC, 1'b1, 32'h0000_1230, 32'h0000_1230}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ic_req_valid;
    logic [31:0]  ic_req_addr;
    logic         ic_resp_hit = 1'b1;
    logic [127:0] ic_resp_line;
    logic         ic_fill_done = 1'b0;
    logic [31:0]  bp_pc;
    logic         bp_taken = 1'b0;
    logic [31:0]  bp_target = '0;
    logic         sq_late_valid = 1'b0;
    logic [31:0]  sq_late_pc = '0;
    logic         sq_dec_valid = 1'b0;
    logic [31:0]  sq_dec_pc = '0;
    logic [7:0]   sq_dec_seq = '0;
    logic         dec_ready = 1'b1;
    logic         dec_valid;
    logic [31:0]  dec_inst;
    logic [31:0]  dec_pc;
    logic         dec_pred_taken;
    logic [7:0]   dec_seq;
    logic [15:0]  stat_miss_cycles;
    logic [15:0]  stat_fetched;
    logic [15:0]  stat_pred_taken;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    logic [15:0] snap;

    always #2.5 clk = ~clk;

    fetch_stage u0 (
        .clk(clk), .rst(rst),
        .ic_req_valid(ic_req_valid), .ic_req_addr(ic_req_addr),
        .ic_resp_hit(ic_resp_hit), .ic_resp_line(ic_resp_line),
        .ic_fill_done(ic_fill_done),
        .bp_pc(bp_pc), .bp_taken(bp_taken), .bp_target(bp_target),
        .sq_late_valid(sq_late_valid), .sq_late_pc(sq_late_pc),
        .sq_dec_valid(sq_dec_valid), .sq_dec_pc(sq_dec_pc), .sq_dec_seq(sq_dec_seq),
        .dec_ready(dec_ready), .dec_valid(dec_valid), .dec_inst(dec_inst),
        .dec_pc(dec_pc), .dec_pred_taken(dec_pred_taken), .dec_seq(dec_seq),
        .stat_miss_cycles(stat_miss_cycles), .stat_fetched(stat_fetched),
        .stat_pred_taken(stat_pred_taken)
    );

    function automatic logic [31:0] word_of(logic [31:0] a);
        return {a[31:4], a[3:2], 2'b11} ^ KEY;
    endfunction

    always_comb begin
        for (int w = 0; w < 4; w++)
            ic_resp_line[w*32 +: 32] = word_of({ic_req_addr[31:4], 2'(w), 2'b00});
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // vector walk over redirect start points (R2, R3, R4, R7)
        repeat (3) tick();
        chk("R1 valid in reset", 32'(dec_valid), 0);
        chk("R1 no req in reset", 32'(ic_req_valid), 0);
        rst = 1'b0;
        #1;
        chk("R1 idle no req", 32'(ic_req_valid), 0);
        chk("R1 lookup pc", bp_pc, 32'h0000_1008);
        chk("R1 counters zero", 32'(stat_miss_cycles) | 32'(stat_fetched) | 32'(stat_pred_taken), 0);
        tick();
        chk("R1 first req", 32'(ic_req_valid), 1);
        chk("R2 first req addr", ic_req_addr, 32'h0000_1000);
        tick();
        chk("R3 valid", 32'(dec_valid), 1);
        chk("R3 pc", dec_pc, 32'h0000_1008);
        chk("R2 word select", dec_inst, word_of(32'h0000_1008));
        chk("R8 first seq", 32'(dec_seq), 0);
        chk("R4 next req addr", ic_req_addr, 32'h0000_1000);
        tick();
        chk("R4 plus four", dec_pc, 32'h0000_100C);
        chk("R8 seq step", 32'(dec_seq), 1);
        chk("R2 block step", ic_req_addr, 32'h0000_1010);
        chk("R11 fetched", 32'(stat_fetched), 2);

        // R6 decode hold
        dec_ready = 1'b0;
        tick();
        chk("R6 held valid", 32'(dec_valid), 1);
        chk("R6 held pc", dec_pc, 32'h0000_100C);
        chk("R6 no req", 32'(ic_req_valid), 0);
        tick();
        chk("R6 still held", dec_inst, word_of(32'h0000_100C));
        dec_ready = 1'b1;
        #1;
        tick();
        chk("R6 drop after accept", 32'(dec_valid), 0);
        chk("R6 resume req", 32'(ic_req_valid), 1);
        chk("R6 resume addr", ic_req_addr, 32'h0000_1010);
        tick();
        chk("R6 resumed pc", dec_pc, 32'h0000_1010);
        chk("R8 seq across hold", 32'(dec_seq), 2);

        // R5 miss
        ic_resp_hit = 1'b0;
        tick();
        ic_resp_hit = 1'b1;
        #1;
        chk("R5 no valid in miss", 32'(dec_valid), 0);
        chk("R5 no req in miss", 32'(ic_req_valid), 0);
        tick();
        tick();
        chk("R5 still waiting", 32'(ic_req_valid), 0);
        ic_fill_done = 1'b1;
        tick();
        ic_fill_done = 1'b0;
        #1;
        chk("R5 re-request", 32'(ic_req_valid), 1);
        chk("R5 re-request addr", ic_req_addr, 32'h0000_1010);
        chk("R11 miss cycles", 32'(stat_miss_cycles), 3);
        tick();
        chk("R5 delivered", dec_pc, 32'h0000_1014);
        chk("R5 delivered valid", 32'(dec_valid), 1);

        foreach (VEC[i]) begin
            sq_late_valid = 1'b1;
            sq_late_pc    = VEC[i].start;
            tick();
            sq_late_valid = 1'b0;
            #1;
            chk("R7 flushed", 32'(dec_valid), 0);
            chk("R7 no req after squash", 32'(ic_req_valid), 0);
            tick();
            bp_taken  = VEC[i].tk;
            bp_target = VEC[i].tgt;
            #1;
            chk("R2 vec req addr", ic_req_addr, VEC[i].start & ~32'hF);
            tick();
            bp_taken = 1'b0;
            chk("R3 vec pc", dec_pc, VEC[i].start);
            chk("R2 vec inst", dec_inst, word_of(VEC[i].start));
            chk("R3 vec pred", 32'(dec_pred_taken), 32'(VEC[i].tk));
            #1;
            chk("R4 vec next block", ic_req_addr, VEC[i].nxt & ~32'hF);
            tick();
            chk("R4 vec next pc", dec_pc, VEC[i].nxt);
        end
        chk("R11 pred count", 32'(stat_pred_taken), 2);

        // R10 squash vs hit
        snap = stat_fetched;
        sq_late_valid = 1'b1;
        sq_late_pc    = 32'h0000_5000;
        tick();
        sq_late_valid = 1'b0;
        chk("R10 no count", 32'(stat_fetched), 32'(snap));
        chk("R10 no delivery", 32'(dec_valid), 0);
        tick();
        tick();
        chk("R10 restart pc", dec_pc, 32'h0000_5000);

        // R7 priority of later-stage redirect
        sq_late_valid = 1'b1; sq_late_pc = 32'h0000_6000;
        sq_dec_valid  = 1'b1; sq_dec_pc  = 32'h0000_7000; sq_dec_seq = 8'h10;
        tick();
        sq_late_valid = 1'b0; sq_dec_valid = 1'b0;
        tick();
        tick();
        chk("R7 late wins", dec_pc, 32'h0000_6000);

        // R8 decode redirect sequence restart
        sq_dec_valid = 1'b1; sq_dec_pc = 32'h0000_7100; sq_dec_seq = 8'h40;
        tick();
        sq_dec_valid = 1'b0;
        tick();
        tick();
        chk("R8 dec pc", dec_pc, 32'h0000_7100);
        chk("R8 seq restart", 32'(dec_seq), 32'h41);
        tick();
        chk("R8 seq next", 32'(dec_seq), 32'h42);

        // R9 stale fill after squash
        ic_resp_hit = 1'b0;
        tick();
        ic_resp_hit = 1'b1;
        sq_late_valid = 1'b1; sq_late_pc = 32'h0000_8000;
        tick();
        sq_late_valid = 1'b0;
        tick();
        ic_resp_hit = 1'b0;
        tick();
        ic_resp_hit = 1'b1;
        ic_fill_done = 1'b1;
        tick();
        ic_fill_done = 1'b0;
        #1;
        chk("R9 stale fill ignored", 32'(ic_req_valid), 0);
        tick();
        chk("R9 still waiting", 32'(ic_req_valid), 0);
        ic_fill_done = 1'b1;
        tick();
        ic_fill_done = 1'b0;
        #1;
        chk("R9 real fill re-request", 32'(ic_req_valid), 1);
        chk("R9 re-request addr", ic_req_addr, 32'h0000_8000);
        tick();
        chk("R9 delivered", dec_pc, 32'h0000_8000);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule